// File: doc/BRIEF.md
# Transmit Frame Formatter with Gated Scrambler

This block assembles the byte-wide transmit frame for a single-carrier link that runs behind a block code. Each frame opens with a fixed four-byte synchronisation word sent in the clear. A header byte follows, then a run of user data bytes pulled from an upstream FIFO read port, then the code's parity bytes, which are fetched from a separate input port. Header, data and parity are XORed with a repeating four-byte scrambling word. The scrambled region is therefore 256 bytes, a whole multiple of the word length, and every frame is 260 bytes long.

Both fixed words come from the two members of a preferred pair of five-stage maximal-length shift registers. Because the pair has low cross-correlation, a receiver searching for the synchronisation word is unlikely to find it inside scrambled payload. Each word is 31 chips followed by one zero pad chip. The output stream carries a valid flag, a start-of-frame flag and a byte-class tag. When the upstream FIFO runs dry in the data phase, the formatter stalls and does not skip ahead.

Top module: `txfmt_top`

## Requirements
- R1: While reset (`rst_n` low) is active, `tx_valid`, `in_ready` and `par_rd` are 0. The first byte produced after reset is the first synchronisation byte of a new frame.
- R2: Frame bytes 0 to 3 are the synchronisation word, sent unscrambled with class 0 and the most significant byte first. These bytes are never stalled. The word's bit 31-k is chip a[k] for k = 0..30 of a[n+5] = a[n+2] xor a[n] with a[0..4] = 1, and bit 0 is 0.
- R3: Frame byte 4 is the header, class 1. Its value is 0x00 XOR scrambling byte 0.
- R4: Frame bytes 5 to 243 are data, class 2. Each is the accepted upstream byte XOR its scrambling byte, and each appears one cycle after its acceptance.
- R5: `in_ready` is 1 exactly while the next frame byte to be produced is a data byte. A byte is accepted on each rising edge where `in_ready` and `in_valid` are both 1.
- R6: When `in_ready` is 1 and `in_valid` is 0, no byte is produced in the following cycle (`tx_valid` = 0), and the frame position does not advance.
- R7: Frame bytes 244 to 259 are parity, class 3. `par_rd` is 1 for exactly those 16 positions, and each output byte is the `par_data` value sampled in that cycle XOR its scrambling byte.
- R8: Scrambling byte k of the word is bits 31-8k down to 24-8k. Frame byte p (p >= 4) uses k = (p-4) mod 4, so the word restarts at byte 0 on every header. The word's bit 31-k is chip b[k] of b[n+5] = b[n+4] xor b[n+3] xor b[n+2] xor b[n] with b[0..4] = 1, and bit 0 is 0.
- R9: `tx_sof` is 1 only on frame byte 0. Consecutive start-of-frame bytes are exactly 260 produced bytes apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Upstream data byte |
| in_valid | input | 1 | Upstream byte available |
| in_ready | output | 1 | Formatter takes a data byte this cycle if valid |
| par_data | input | 8 | Parity byte for the current parity position |
| par_rd | output | 1 | Parity byte on `par_data` is consumed this cycle |
| tx_data | output | 8 | Frame byte out |
| tx_valid | output | 1 | `tx_data` holds a frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_class | output | 2 | 0 sync, 1 header, 2 data, 3 parity |

## Verification
The formatter is driven with upstream valid patterns that range from always valid, through alternating and sparse gaps, to one byte every sixteen cycles. This separates a formatter that advances on every cycle from one that holds its position until data arrives. It also shows whether the scrambling lane follows bytes produced or clock cycles. Long stalls placed on the first and last data positions expose off-by-one errors at the data/header and data/parity borders. A reset in mid-frame checks that the frame position and the scrambler phase both restart.

// File: rtl/txfmt_pkg.sv
package txfmt_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned PN_STAGES  = 5;
    localparam int unsigned PN_CHIPS   = (1 << PN_STAGES) - 1;
    localparam int unsigned WORD_BITS  = PN_CHIPS + 1;
    localparam int unsigned WORD_BYTES = WORD_BITS / BYTE_W;
    localparam int unsigned LANE_W     = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        CLS_PRE  = 2'd0,
        CLS_HDR  = 2'd1,
        CLS_DATA = 2'd2,
        CLS_PAR  = 2'd3
    } byte_class_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              sof;
        byte_class_e       cls;
    } tx_beat_t;

    // Chip k of the recurrence lands on bit WORD_BITS-1-k; the last bit is a zero pad.
    // taps[i] selects chip n-PN_STAGES+i in the sum that forms chip n.
    function automatic logic [WORD_BITS-1:0] pn_word(input logic [PN_STAGES-1:0] taps,
                                                     input logic [PN_STAGES-1:0] seed);
        logic [PN_CHIPS-1:0] c;
        logic [WORD_BITS-1:0] w;
        c = '0;
        w = '0;
        for (int n = 0; n < PN_CHIPS; n++) begin
            if (n < PN_STAGES) c[n] = seed[PN_STAGES-1-n];
            else               c[n] = ^(taps & c[n-PN_STAGES +: PN_STAGES]);
        end
        for (int k = 0; k < PN_CHIPS; k++) w[WORD_BITS-1-k] = c[k];
        return w;
    endfunction

endpackage

// File: rtl/txfmt_seq.sv
module txfmt_seq
    import txfmt_pkg::*;
#(
    parameter int unsigned N_DATA = 239,
    parameter int unsigned N_PAR  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    output byte_class_e       cls_o,
    output logic              advance_o,
    output logic              sof_o,
    output logic              in_ready_o,
    output logic              par_rd_o,
    output logic [LANE_W-1:0] lane_o,
    output logic [LANE_W-1:0] pre_idx_o
);

    localparam int unsigned HDR_POS   = WORD_BYTES;
    localparam int unsigned DATA_LO   = HDR_POS + 1;
    localparam int unsigned PAR_LO    = DATA_LO + N_DATA;
    localparam int unsigned FRAME_LEN = PAR_LO + N_PAR;
    localparam int unsigned POS_W     = $clog2(FRAME_LEN);

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [LANE_W-1:0] lane;
    } seq_st_t;

    localparam seq_st_t ST_RST = '{pos: '0, lane: '0};

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (st_q.pos < POS_W'(HDR_POS))       cls_o = CLS_PRE;
        else if (st_q.pos == POS_W'(HDR_POS)) cls_o = CLS_HDR;
        else if (st_q.pos < POS_W'(PAR_LO))   cls_o = CLS_DATA;
        else                                  cls_o = CLS_PAR;

        advance_o  = (cls_o != CLS_DATA) || in_valid_i;
        sof_o      = (st_q.pos == '0);
        in_ready_o = (cls_o == CLS_DATA);
        par_rd_o   = (cls_o == CLS_PAR);
        lane_o     = (cls_o == CLS_HDR) ? '0 : st_q.lane;
        pre_idx_o  = st_q.pos[LANE_W-1:0];

        if (advance_o) begin
            st_d.pos = (st_q.pos == POS_W'(FRAME_LEN - 1)) ? '0 : st_q.pos + POS_W'(1);
            if (cls_o != CLS_PRE) st_d.lane = lane_o + LANE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/txfmt_scram.sv
module txfmt_scram
    import txfmt_pkg::*;
#(
    parameter logic [WORD_BITS-1:0] PRE_WORD = '0,
    parameter logic [WORD_BITS-1:0] SCR_WORD = '0,
    parameter logic [BYTE_W-1:0]    HDR_VAL  = '0
) (
    input  byte_class_e       cls_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [LANE_W-1:0] pre_idx_i,
    input  logic [BYTE_W-1:0] in_data_i,
    input  logic [BYTE_W-1:0] par_data_i,
    output logic [BYTE_W-1:0] byte_o
);

    logic [BYTE_W-1:0] pre_b [WORD_BYTES];
    logic [BYTE_W-1:0] scr_b [WORD_BYTES];

    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
        assign pre_b[k] = PRE_WORD[WORD_BITS-1-BYTE_W*k -: BYTE_W];
        assign scr_b[k] = SCR_WORD[WORD_BITS-1-BYTE_W*k -: BYTE_W];
    end

    logic [BYTE_W-1:0] plain;
    logic [BYTE_W-1:0] mask;

    always_comb begin
        mask = scr_b[lane_i];
        unique case (cls_i)
            CLS_PRE:  plain = pre_b[pre_idx_i];
            CLS_HDR:  plain = HDR_VAL;
            CLS_DATA: plain = in_data_i;
            CLS_PAR:  plain = par_data_i;
            default:  plain = '0;
        endcase
        byte_o = (cls_i == CLS_PRE) ? plain : (plain ^ mask);
    end

endmodule

// File: rtl/txfmt_top.sv
module txfmt_top
    import txfmt_pkg::*;
#(
    parameter int unsigned          N_DATA   = 239,
    parameter int unsigned          N_PAR    = 16,
    parameter logic [BYTE_W-1:0]    HDR_VAL  = 8'h00,
    parameter logic [PN_STAGES-1:0] PRE_TAPS = 5'b00101,
    parameter logic [PN_STAGES-1:0] SCR_TAPS = 5'b11101,
    parameter logic [PN_STAGES-1:0] PN_SEED  = 5'b11111
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  par_data,
    output logic        par_rd,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_sof,
    output logic [1:0]  tx_class
);

    localparam logic [WORD_BITS-1:0] PRE_WORD = pn_word(PRE_TAPS, PN_SEED);
    localparam logic [WORD_BITS-1:0] SCR_WORD = pn_word(SCR_TAPS, PN_SEED);
    localparam tx_beat_t BEAT_RST = '{data: '0, valid: 1'b0, sof: 1'b0, cls: CLS_PRE};

    byte_class_e       cls;
    logic              advance;
    logic              sof;
    logic [LANE_W-1:0] lane;
    logic [LANE_W-1:0] pre_idx;
    logic [BYTE_W-1:0] byte_out;

    txfmt_seq #(
        .N_DATA (N_DATA),
        .N_PAR  (N_PAR)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .cls_o      (cls),
        .advance_o  (advance),
        .sof_o      (sof),
        .in_ready_o (in_ready),
        .par_rd_o   (par_rd),
        .lane_o     (lane),
        .pre_idx_o  (pre_idx)
    );

    txfmt_scram #(
        .PRE_WORD (PRE_WORD),
        .SCR_WORD (SCR_WORD),
        .HDR_VAL  (HDR_VAL)
    ) u_scram (
        .cls_i      (cls),
        .lane_i     (lane),
        .pre_idx_i  (pre_idx),
        .in_data_i  (in_data),
        .par_data_i (par_data),
        .byte_o     (byte_out)
    );

    tx_beat_t beat_d, beat_q;

    always_comb begin
        beat_d       = beat_q;
        beat_d.valid = advance;
        beat_d.sof   = sof && advance;
        beat_d.cls   = cls;
        beat_d.data  = byte_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_q <= BEAT_RST;
        else        beat_q <= beat_d;
    end

    assign tx_data  = beat_q.data;
    assign tx_valid = beat_q.valid;
    assign tx_sof   = beat_q.sof;
    assign tx_class = beat_q.cls;

endmodule

// File: rtl/txfmt_top_chk.sv
module txfmt_top_chk
    import txfmt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       par_rd,
    input logic       tx_valid,
    input logic       tx_sof,
    input logic [1:0] tx_class
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_rst_quiet_R1: assert (!tx_valid && !in_ready && !par_rd)
                else $error("outputs active during reset");
        end
    end

    assert_pre_nostall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_class == CLS_PRE) |=> tx_valid);

    assert_sof_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sof) |=> (tx_valid && tx_class == CLS_PRE && !tx_sof));

    assert_hdr_after_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_class == CLS_HDR) |-> ($past(tx_valid) && $past(tx_class) == CLS_PRE));

    assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (tx_valid && tx_class == CLS_DATA));

    assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !tx_valid);

    assert_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        par_rd |=> (tx_valid && tx_class == CLS_PAR));

    assert_sof_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sof) |-> (tx_class == CLS_PRE));

endmodule

bind txfmt_top txfmt_top_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .par_rd   (par_rd),
    .tx_valid (tx_valid),
    .tx_sof   (tx_sof),
    .tx_class (tx_class)
);

// File: tb/txfmt_top_tb_top.sv
`timescale 1ns/1ps
module txfmt_top_tb_top;

    localparam int N_DATA  = 239;
    localparam int N_PAR   = 16;
    localparam int DATA_LO = 5;
    localparam int PAR_LO  = DATA_LO + N_DATA;
    localparam int FRAME   = PAR_LO + N_PAR;
    localparam int N_VEC   = 6;
    // {valid period, gap cycles per period, frames to run, expected frame length}
    localparam logic [31:0] VEC [N_VEC] = '{
        {8'd0,  8'd0,  8'd2, 8'(FRAME)},
        {8'd2,  8'd1,  8'd1, 8'(FRAME)},
        {8'd7,  8'd3,  8'd1, 8'(FRAME)},
        {8'd16, 8'd15, 8'd1, 8'(FRAME)},
        {8'd5,  8'd1,  8'd1, 8'(FRAME)},
        {8'd3,  8'd2,  8'd1, 8'(FRAME)}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic [7:0] par_data = '0;
    logic       in_ready, par_rd, tx_valid, tx_sof;
    logic [7:0] tx_data;
    logic [1:0] tx_class;

    always #5 clk = ~clk;

    txfmt_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .par_data (par_data),
        .par_rd   (par_rd),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_sof   (tx_sof),
        .tx_class (tx_class)
    );

    int errors = 0, checks = 0;
    int epos = 0, dcnt = 0, pcnt = 0, src_cnt = 0, par_cnt = 0, cyc = 0;
    int since_sof = -1, frames_done = 0, period = 0, gap = 0, exp_len = FRAME;
    bit stall_force = 1'b0, prev_stall = 1'b0;
    logic [31:0] pre_w, scr_w;

    function automatic logic [7:0] mk(int n);
        return 8'((n * 29 + 90) ^ (n >> 3));
    endfunction

    function automatic logic [7:0] mkp(int n);
        return 8'((n * 11) ^ 8'hC3);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] scr_byte(int p);
        int k = (p - 4) % 4;
        return scr_w[31 - 8*k -: 8];
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            chk(!tx_valid && !in_ready && !par_rd, "R1", "outputs in reset",
                {tx_valid, in_ready, par_rd}, 0);
            epos = 0; dcnt = 0; pcnt = 0; src_cnt = 0; par_cnt = 0;
            since_sof = -1; prev_stall = 1'b0; in_valid = 1'b0;
        end else begin
            if (prev_stall) chk(!tx_valid, "R6", "byte produced during stall", tx_valid, 0);
            if (tx_valid) begin
                chk(tx_sof == (epos == 0), "R9", "sof flag", tx_sof, epos == 0);
                if (tx_sof) begin
                    if (since_sof >= 0) chk(since_sof == exp_len, "R9", "frame length", since_sof, exp_len);
                    since_sof = 0;
                end
                if (since_sof >= 0) since_sof++;
                if (epos < 4) begin
                    chk(tx_data == pre_w[31 - 8*epos -: 8], "R2", "sync byte", tx_data, pre_w[31 - 8*epos -: 8]);
                    chk(tx_class == 2'd0, "R2", "sync class", tx_class, 0);
                end else if (epos == 4) begin
                    chk(tx_data == scr_w[31:24], "R3", "header byte", tx_data, scr_w[31:24]);
                    chk(tx_class == 2'd1, "R3", "header class", tx_class, 1);
                end else if (epos < PAR_LO) begin
                    chk(tx_data == (mk(dcnt) ^ scr_byte(epos)), "R4 R8", "data byte", tx_data, mk(dcnt) ^ scr_byte(epos));
                    chk(tx_class == 2'd2, "R4", "data class", tx_class, 2);
                    dcnt++;
                end else begin
                    chk(tx_data == (mkp(pcnt) ^ scr_byte(epos)), "R7 R8", "parity byte", tx_data, mkp(pcnt) ^ scr_byte(epos));
                    chk(tx_class == 2'd3, "R7", "parity class", tx_class, 3);
                    pcnt++;
                end
                epos++;
                if (epos == FRAME) begin
                    epos = 0;
                    frames_done++;
                end
            end
            chk(in_ready == (epos >= DATA_LO && epos < PAR_LO), "R5", "in_ready", in_ready, epos >= DATA_LO && epos < PAR_LO);
            chk(par_rd == (epos >= PAR_LO), "R7", "par_rd", par_rd, epos >= PAR_LO);
            in_valid = !stall_force && (period == 0 || (cyc % period) >= gap);
            in_data  = mk(src_cnt);
            if (in_valid && in_ready) src_cnt++;
            par_data = mkp(par_cnt);
            if (par_rd) par_cnt++;
            prev_stall = in_ready && !in_valid;
        end
    end

    task automatic wait_frames(int n);
        int target = frames_done + n;
        while (frames_done < target) @(negedge clk);
    endtask

    task automatic stall_at(int p, int len);
        while (epos != p) @(negedge clk);
        stall_force = 1'b1;
        repeat (len) @(negedge clk);
        stall_force = 1'b0;
    endtask

    initial begin
        logic a [31];
        for (int n = 0; n < 31; n++) a[n] = (n < 5) ? 1'b1 : (a[n-3] ^ a[n-5]);
        pre_w = '0;
        for (int k = 0; k < 31; k++) pre_w[31-k] = a[k];
        for (int n = 0; n < 31; n++) a[n] = (n < 5) ? 1'b1 : (a[n-1] ^ a[n-2] ^ a[n-3] ^ a[n-5]);
        scr_w = '0;
        for (int k = 0; k < 31; k++) scr_w[31-k] = a[k];

        // R1: reset state, then release away from the clock edges
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        for (int v = 0; v < N_VEC; v++) begin
            period  = int'(VEC[v][31:24]);
            gap     = int'(VEC[v][23:16]);
            exp_len = int'(VEC[v][7:0]) + 256;
            wait_frames(int'(VEC[v][15:8]));
        end
        period = 0; gap = 0;

        // R6: long stall on first data position, short stall on last data position
        stall_at(DATA_LO, 40);
        stall_at(PAR_LO - 1, 5);
        wait_frames(1);

        // R1 R8: reset in mid-data, phase and position must restart
        while (epos != 100) @(negedge clk);
        @(posedge clk); #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        wait_frames(2);

        chk(frames_done >= 10, "R9", "frames completed", frames_done, 10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", frames_done, 10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule